// File: doc/BRIEF.md
# SDRAM Read Burst Output Sequencer

This block sequences the read-data side of one synchronous DRAM bank. Each clock it takes one command (no-op, read, write or precharge) together with a column address. A read starts a burst. The burst walks a set of columns in either sequential or interleaved order, over a fixed length of 1, 2, 4 or 8 beats or over the whole page. Every beat is fetched from a small internal register file and placed on an output bus after the programmed CAS latency of 1, 2 or 3 clocks. A separate output-enable bit tells the surrounding pad logic when the bus is being driven.

A data-mask input acts two clocks late and blanks single beats. Blanked beats still advance the burst. Any later command can take over a running burst. A new read replaces the old beats from its own latency slot onwards. A precharge stops new beats but lets the beats already in flight drain. A write stops the burst at once, discards every beat still in flight and stores its data word into the array. The burst mode, CAS latency and ordering are static inputs and are set up before reads are issued.

Top module: `sdram_rd_seq`

## Requirements
- R1: After synchronous reset, dq_oe_o is low and dq_out_o is zero until a read's first beat falls due. The array word at column i reads as the low DATA_W bits of (i * 0x9E37) XOR 0x12345678.
- R2: A READ issued in cycle t with cas_lat_i = L (1, 2 or 3) drives its first beat in cycle t+L. That beat is the array word at the READ's column.
- R3: burst_code_i selects 2^code[1:0] beats when its value is not 7. With sequential order, beat k reads column (base & ~m) | ((base + k) & m), where m is the length minus one. Once the burst is done, dq_oe_o returns low and dq_out_o reads zero.
- R4: With interleave_i high and a fixed length, beat k reads column base XOR (k & m).
- R5: burst_code_i = 7 selects full-page mode. The burst runs until another command stops it, and its columns go base, base+1, … modulo 2^COL_W, so column 0 follows the last column.
- R6: A high dqm_i in cycle t forces dq_oe_o low in cycle t+2. The blanked beat is still counted as part of the burst.
- R7: A READ issued while an earlier burst is running or draining takes over the bus at its own slot t+L. Earlier beats that fall due before that slot are still driven.
- R8: A PRECHARGE in cycle p stops beat issue. The last beat that can be driven falls in cycle p+L-1, and the bus is released after it.
- R9: In the cycle a WRITE is presented and in every later cycle, dq_oe_o stays low until a new READ's beats fall due. The write word is stored at its column and is returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 0 no-op, 1 read, 2 write, 3 precharge |
| col_i | input | COL_W | Column address for read or write |
| wr_data_i | input | DATA_W | Write word, valid with a write command |
| dqm_i | input | 1 | Data mask, acts two clocks later |
| cas_lat_i | input | 2 | CAS latency in clocks (1 to 3), static |
| burst_code_i | input | 3 | Burst length code, 7 for full page, static |
| interleave_i | input | 1 | 1 selects interleaved beat order, static |
| dq_oe_o | output | 1 | Bus driven this cycle |
| dq_out_o | output | DATA_W | Read beat, zero when not driven |

## Verification
The bench builds the block with its defaults: COL_W = 4 gives a 16-column page, and DATA_W = 16. The short page lets a full-page burst wrap past column 0 inside a few dozen clocks. Every CAS latency and every length code, including the codes that alias onto the fixed lengths, can then be combined in one run with interrupts, masks, precharges and writes. Because the array is only 16 words, random writes and reads often hit the same column, so read-after-write data is checked as a matter of course.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_PRE   = 2'd3
    } sdrs_cmd_e;

    typedef struct packed {
        logic [1:0] cas;
        logic [2:0] bl;
        logic       ilv;
    } sdrs_mode_t;

    localparam int          MAX_CL  = 3;
    localparam logic [2:0]  BL_PAGE = 3'd7;

    function automatic logic [31:0] fill_word(input int unsigned idx);
        return (idx * 32'h0000_9E37) ^ 32'h1234_5678;
    endfunction

endpackage

// File: rtl/sdrs_regfile.sv
module sdrs_regfile #(
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [COL_W-1:0]  wcol,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  rcol,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [DATA_W-1:0] init_of(input int unsigned i);
        logic [31:0] w;
        w = sdrs_pkg::fill_word(i);
        return w[DATA_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_of(i);
        end else if (we) begin
            mem[wcol] <= wdata;
        end
    end

    assign rdata = mem[rcol];

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst) && rcol == $past(wcol)) |-> rdata == $past(wdata));

endmodule

// File: rtl/sdrs_beat_gen.sv
module sdrs_beat_gen
    import sdrs_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  sdrs_cmd_e        cmd,
    input  logic [COL_W-1:0] col,
    input  logic [2:0]       bl_code,
    input  logic             ilv,
    output logic             iss_vld,
    output logic [COL_W-1:0] iss_col
);
    logic             active_q, active_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] k_q, k_d;
    logic             page;
    logic [COL_W-1:0] len_mask;
    logic [31:0]      mask_w;

    always_comb begin
        page   = (bl_code == BL_PAGE);
        mask_w = (32'd1 << bl_code[1:0]) - 32'd1;
        len_mask = page ? '1 : mask_w[COL_W-1:0];
    end

    function automatic logic [COL_W-1:0] col_of(
        input logic [COL_W-1:0] b,
        input logic [COL_W-1:0] k,
        input logic [COL_W-1:0] m,
        input logic             inter,
        input logic             pg
    );
        if (inter && !pg) return b ^ (k & m);
        return (b & ~m) | ((b + k) & m);
    endfunction

    always_comb begin
        iss_vld  = 1'b0;
        iss_col  = '0;
        active_d = active_q;
        base_d   = base_q;
        k_d      = k_q;
        unique case (cmd)
            CMD_READ: begin
                iss_vld  = 1'b1;
                iss_col  = col;
                base_d   = col;
                k_d      = COL_W'(1);
                active_d = page || (len_mask != '0);
            end
            CMD_WRITE, CMD_PRE: begin
                active_d = 1'b0;
            end
            default: begin
                if (active_q) begin
                    iss_vld = 1'b1;
                    iss_col = col_of(base_q, k_q, len_mask, ilv, page);
                    k_d     = k_q + COL_W'(1);
                    if (!page && k_q == len_mask) active_d = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            k_q      <= '0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            k_q      <= k_d;
        end
    end

    // R3
    beat_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !page) |-> (k_q != '0 && k_q <= len_mask));

    // R8
    pre_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |=> (!iss_vld || cmd == CMD_READ));

endmodule

// File: rtl/sdrs_lat_pipe.sv
module sdrs_lat_pipe #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              kill,
    input  logic              dqm,
    input  logic [1:0]        cas,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);
    logic [DEPTH-1:0]  vld_q;
    logic [DATA_W-1:0] dat_q [DEPTH];
    logic [1:0]        dqm_q;
    int                tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            dqm_q <= '0;
        end else begin
            vld_q <= kill ? '0 : {vld_q[DEPTH-2:0], in_vld};
            dqm_q <= {dqm_q[0], dqm};
        end
        dat_q[0] <= in_data;
        for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
    end

    always_comb begin
        tap = (cas == 2'd0) ? 0 : int'(cas) - 1;
        if (tap > DEPTH - 1) tap = DEPTH - 1;
        dq_oe  = vld_q[tap] & ~dqm_q[1] & ~kill;
        dq_out = dq_oe ? dat_q[tap] : '0;
    end

    // R6
    dqm_blank_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dqm, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> !dq_oe);

    // R9
    wr_kill_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> !dq_oe);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdrs_pkg::*;
#(
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              dqm_i,
    input  logic [1:0]        cas_lat_i,
    input  logic [2:0]        burst_code_i,
    input  logic              interleave_i,
    output logic              dq_oe_o,
    output logic [DATA_W-1:0] dq_out_o
);
    sdrs_cmd_e         cmd;
    sdrs_mode_t        mode;
    logic              iss_vld;
    logic [COL_W-1:0]  iss_col;
    logic [DATA_W-1:0] iss_data;
    logic              wr_now;

    assign cmd    = sdrs_cmd_e'(cmd_i);
    assign mode   = '{cas: cas_lat_i, bl: burst_code_i, ilv: interleave_i};
    assign wr_now = (cmd == CMD_WRITE);

    sdrs_beat_gen #(.COL_W(COL_W)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .col     (col_i),
        .bl_code (mode.bl),
        .ilv     (mode.ilv),
        .iss_vld (iss_vld),
        .iss_col (iss_col)
    );

    sdrs_regfile #(.COL_W(COL_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_now),
        .wcol  (col_i),
        .wdata (wr_data_i),
        .rcol  (iss_col),
        .rdata (iss_data)
    );

    sdrs_lat_pipe #(.DATA_W(DATA_W), .DEPTH(MAX_CL)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (iss_vld),
        .in_data (iss_data),
        .kill    (wr_now),
        .dqm     (dqm_i),
        .cas     (mode.cas),
        .dq_oe   (dq_oe_o),
        .dq_out  (dq_out_o)
    );

    // R9
    wr_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
        wr_now |-> !dq_oe_o);

endmodule

// File: tb/sdram_rd_seq_tb_top.sv
module sdram_rd_seq_tb_top;
    localparam int CW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    cmd_i;
    logic [CW-1:0] col_i;
    logic [DW-1:0] wr_data_i;
    logic          dqm_i;
    logic [1:0]    cas_lat_i;
    logic [2:0]    burst_code_i;
    logic          interleave_i;
    logic          dq_oe_o;
    logic [DW-1:0] dq_out_o;

    always #10 clk = ~clk;

    sdram_rd_seq #(.COL_W(CW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .col_i(col_i),
        .wr_data_i(wr_data_i), .dqm_i(dqm_i), .cas_lat_i(cas_lat_i),
        .burst_code_i(burst_code_i), .interleave_i(interleave_i),
        .dq_oe_o(dq_oe_o), .dq_out_o(dq_out_o)
    );

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    string req  = "R1";

    logic [DW-1:0] mm [16];
    bit            ev [16];
    logic [DW-1:0] ed [16];
    bit            dv [16];
    int cl = 1, blc = 2;
    bit ilv = 0;
    bit mact = 0;
    int mbase = 0, mk = 0;

    function automatic int mask_of(int code);
        if (code == 7) return 15;
        return (1 << (code & 3)) - 1;
    endfunction

    function automatic int colx(int base, int k);
        int m;
        m = mask_of(blc);
        if (ilv && blc != 7) return base ^ (k & m);
        return (base & ~m & 15) | ((base + k) & m);
    endfunction

    task automatic chk(bit ok, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic issue(int c);
        ev[(cyc + cl) % 16] = 1'b1;
        ed[(cyc + cl) % 16] = mm[c];
    endtask

    task automatic tick(int cmd, int col, int wd, bit dqm);
        int s;
        bit eoe;
        @(negedge clk);
        cmd_i = 2'(cmd); col_i = CW'(col); wr_data_i = DW'(wd); dqm_i = dqm;
        #2;
        s   = cyc % 16;
        eoe = ev[s] && !dv[s] && cmd != 2;
        chk(dq_oe_o == eoe, "dq_oe", int'(dq_oe_o), int'(eoe));
        if (eoe) chk(dq_out_o == ed[s], "dq_out", int'(dq_out_o), int'(ed[s]));
        else     chk(dq_out_o == '0, "idle dq_out", int'(dq_out_o), 0);
        ev[s] = 1'b0;
        dv[s] = 1'b0;
        dv[(cyc + 2) % 16] = dqm;
        case (cmd)
            1: begin
                mbase = col; mk = 1;
                mact  = (blc == 7) || ((blc & 3) != 0);
                issue(col);
            end
            2: begin
                for (int i = 0; i < 16; i++) ev[i] = 1'b0;
                mm[col] = DW'(wd);
                mact = 0;
            end
            3: mact = 0;
            default: begin
                if (mact) begin
                    issue(colx(mbase, mk));
                    if (blc != 7 && mk == mask_of(blc)) mact = 0;
                    mk = (mk + 1) % 16;
                end
            end
        endcase
        cyc++;
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 1'b0);
    endtask

    task automatic setmode(int c, int b, bit il);
        tick(3, 0, 0, 1'b0);
        nops(6);
        cl = c; blc = b; ilv = il;
        cas_lat_i = 2'(c); burst_code_i = 3'(b); interleave_i = il;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        for (int i = 0; i < 16; i++) begin
            mm[i] = DW'((i * 32'h9E37) ^ 32'h1234_5678);
            ev[i] = 0; dv[i] = 0; ed[i] = '0;
        end
        rst = 1'b1; cmd_i = 2'd0; col_i = '0; wr_data_i = '0; dqm_i = 1'b0;
        cas_lat_i = 2'd1; burst_code_i = 3'd2; interleave_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        req = "R1"; nops(3);
        tick(1, 9, 0, 0); nops(4);

        req = "R2";
        for (int c = 1; c <= 3; c++) begin
            setmode(c, 2, 0);
            tick(1, 5, 0, 0); nops(7);
        end

        req = "R3";
        setmode(2, 3, 0); tick(1, 3, 0, 0); nops(10);
        setmode(1, 0, 0); tick(1, 6, 0, 0); nops(3);
        setmode(3, 1, 0); tick(1, 7, 0, 0); nops(5);
        setmode(2, 5, 0); tick(1, 14, 0, 0); nops(5);

        req = "R4";
        setmode(2, 3, 1); tick(1, 5, 0, 0); nops(10);
        setmode(1, 2, 1); tick(1, 10, 0, 0); nops(6);

        req = "R5";
        setmode(1, 7, 0); tick(1, 14, 0, 0); nops(20);
        req = "R8";
        tick(3, 0, 0, 0); nops(5);
        setmode(3, 7, 0); tick(1, 2, 0, 0); nops(4);
        tick(3, 0, 0, 0); nops(6);
        setmode(2, 2, 0); tick(1, 0, 0, 0); tick(3, 0, 0, 0); nops(5);

        req = "R6";
        setmode(2, 2, 0);
        tick(1, 4, 0, 0); tick(0, 0, 0, 1); tick(0, 0, 0, 0); tick(0, 0, 0, 1);
        nops(6);

        req = "R7";
        setmode(3, 2, 0);
        tick(1, 0, 0, 0); tick(0, 0, 0, 0); tick(1, 8, 0, 0); nops(8);
        tick(1, 1, 0, 0); tick(1, 9, 0, 0); tick(1, 12, 0, 0); nops(8);

        req = "R9";
        setmode(3, 3, 0);
        tick(1, 0, 0, 0); tick(0, 0, 0, 0); tick(0, 0, 0, 1); tick(0, 0, 0, 1);
        tick(2, 2, 16'hBEEF, 1); nops(5);
        setmode(1, 2, 0);
        tick(1, 0, 0, 0); tick(0, 0, 0, 0); tick(2, 6, 16'h1234, 0); nops(3);
        tick(1, 2, 0, 0); nops(4); tick(1, 6, 0, 0); nops(4);

        req = "R7";
        for (int r = 0; r < 10; r++) begin
            setmode(1 + int'($urandom % 3), int'($urandom % 8), bit'($urandom % 2));
            for (int n = 0; n < 80; n++) begin
                int p, cmd;
                p = int'($urandom % 100);
                cmd = (p < 25) ? 1 : (p < 33) ? 3 : (p < 41) ? 2 : 0;
                tick(cmd, int'($urandom % 16), int'($urandom % 65536), ($urandom % 5) == 0);
            end
        end
        setmode(1, 2, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule